// File: doc/BRIEF.md
# Lexical-Level Operand Address Walker

This block turns a non-local variable reference into a data-memory address. A request carries a count of lexical levels to climb and a word offset, and arrives with the base of the current activation frame. For every level the block reads the static link held inside the current frame's five-word mark area to find the enclosing frame's base. When the count is used up it adds the offset to the base it reached. A count of zero names the local frame and needs no memory traffic, so the latency varies from one cycle to one read per level plus one.

Requests use a valid/ready handshake. The result is held with a valid flag until the consumer takes it, and `busy` covers the whole operation. The block also watches the downward-growing stack pointer and the upward-growing heap pointer. If an update makes them meet, it raises a sticky overflow that halts further address generation.

Top module: `lex_addr_walker`

## Requirements
- R1: After reset `reqReady` is 1, and `busy`, `resValid`, `memRdEn` and `overflow` are 0.
- R2: A request accepted with a level count of 0 makes no memory read. `resValid` is high in the cycle after acceptance, with `resAddr` = `frameBase` + zero-extended `reqOffset`, modulo 2^AW.
- R3: A request with level count n > 0 makes exactly n reads. The first is at `frameBase`+3. Each later read is at the data returned by the previous read plus 3. The link sits at word index 3 of the mark area.
- R4: After the n-th read is acknowledged, `resValid` rises with `resAddr` = (data returned by the n-th read) + `reqOffset`, modulo 2^AW.
- R5: While `memRdEn` is high and `memRdAck` is low, `memRdEn` stays high and `memRdAddr` holds its value in the next cycle.
- R6: `busy` is high from the cycle after acceptance until the cycle after `resValid` meets `resReady`. While busy, `reqReady` is low and `reqValid` with any field values is ignored.
- R7: While `resValid` is high and `resReady` is low, `resValid` stays high and `resAddr` holds its value.
- R8: Writing either pointer (`spWr`/`hpWr`, both allowed in one cycle) sets `overflow` in the next cycle when the updated stack pointer is less than or equal to the updated heap pointer. Once set, `overflow` stays set until reset. The reset pointer values are all ones and zero.
- R9: While `overflow` is high, `reqReady` is low and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqLevels | input | LW | Lexical levels to climb |
| reqOffset | input | OW | Word offset within the final frame |
| frameBase | input | AW | Base of the current frame |
| memRdEn | output | 1 | Link read request |
| memRdAddr | output | AW | Link read address |
| memRdData | input | AW | Link value returned |
| memRdAck | input | 1 | Read data valid this cycle |
| resValid | output | 1 | Result address valid |
| resReady | input | 1 | Result taken |
| resAddr | output | AW | Computed operand address |
| busy | output | 1 | Walk or result pending |
| spWr | input | 1 | Stack pointer update |
| spData | input | AW | New stack pointer |
| hpWr | input | 1 | Heap pointer update |
| hpData | input | AW | New heap pointer |
| overflow | output | 1 | Stack has met heap (sticky) |

## Verification
The properties assume that the memory acknowledges only while `memRdEn` is high, and that the result consumer may stall it for any number of cycles. The bench's memory responder raises `memRdAck` only for a pending read, after a random wait of zero to two cycles, and drops it for one cycle after every acknowledge. Random pointer updates keep the stack pointer in the upper half and the heap pointer in the lower half, so the two only meet in the directed overflow sequence at the end of the run.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_DONE = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture request fields
    logic loadLink;  // step to enclosing frame
  } walkStrobe_t;
endpackage

// File: rtl/lw_dpath.sv
module lw_dpath
  import lw_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 6,
  parameter int LW = 4,
  parameter int LINK_IDX = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  walkStrobe_t   strobe,
  input  logic [LW-1:0] reqLevels,
  input  logic [OW-1:0] reqOffset,
  input  logic [AW-1:0] frameBase,
  input  logic [AW-1:0] memRdData,
  output logic [AW-1:0] linkAddr,
  output logic [AW-1:0] sumAddr,
  output logic          lastLevel
);
  localparam logic [AW-1:0] LINK_OFS = AW'(LINK_IDX);
  localparam logic [LW-1:0] ONE_LVL  = LW'(1);

  logic [AW-1:0] curBase;
  logic [LW-1:0] remLevels;
  logic [OW-1:0] offsetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBase   <= '0;
      remLevels <= '0;
      offsetQ   <= '0;
    end else if (strobe.loadReq) begin
      curBase   <= frameBase;
      remLevels <= reqLevels;
      offsetQ   <= reqOffset;
    end else if (strobe.loadLink) begin
      curBase   <= memRdData;
      remLevels <= remLevels - ONE_LVL;
    end
  end

  always_comb begin
    linkAddr  = curBase + LINK_OFS;
    sumAddr   = curBase + AW'(offsetQ);
    lastLevel = (remLevels == ONE_LVL);
  end
endmodule

// File: rtl/lw_ctrl.sv
module lw_ctrl
  import lw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsLocal,
  input  logic        lastLevel,
  input  logic        memRdAck,
  input  logic        resReady,
  input  logic        overflow,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memRdEn,
  output logic        resValid,
  output logic        busy
);
  walkState_t state, stateNext;
  logic accept;

  always_comb begin
    reqReady = (state == ST_IDLE) && !overflow;
    accept   = reqValid && reqReady;
    memRdEn  = (state == ST_LINK);
    resValid = (state == ST_DONE);
    busy     = (state != ST_IDLE);
    strobe.loadReq  = accept;
    strobe.loadLink = (state == ST_LINK) && memRdAck;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = reqIsLocal ? ST_DONE : ST_LINK;
      ST_LINK: if (memRdAck && lastLevel) stateNext = ST_DONE;
      ST_DONE: if (resReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/lw_guard.sv
module lw_guard #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_INIT = '1,
  parameter logic [AW-1:0] HP_INIT = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          spWr,
  input  logic [AW-1:0] spData,
  input  logic          hpWr,
  input  logic [AW-1:0] hpData,
  output logic          overflow
);
  logic [AW-1:0] spQ, hpQ, spNext, hpNext;
  logic ovfQ;

  always_comb begin
    spNext = spWr ? spData : spQ;
    hpNext = hpWr ? hpData : hpQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ  <= SP_INIT;
      hpQ  <= HP_INIT;
      ovfQ <= 1'b0;
    end else if (spWr || hpWr) begin
      spQ <= spNext;
      hpQ <= hpNext;
      if (spNext <= hpNext) ovfQ <= 1'b1;
    end
  end

  assign overflow = ovfQ;
endmodule

// File: rtl/lex_addr_walker.sv
module lex_addr_walker
  import lw_pkg::*;
#(
  parameter int AW = 8,
  parameter int OW = 6,
  parameter int LW = 4,
  parameter int LINK_IDX = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [LW-1:0] reqLevels,
  input  logic [OW-1:0] reqOffset,
  input  logic [AW-1:0] frameBase,
  output logic          memRdEn,
  output logic [AW-1:0] memRdAddr,
  input  logic [AW-1:0] memRdData,
  input  logic          memRdAck,
  output logic          resValid,
  input  logic          resReady,
  output logic [AW-1:0] resAddr,
  output logic          busy,
  input  logic          spWr,
  input  logic [AW-1:0] spData,
  input  logic          hpWr,
  input  logic [AW-1:0] hpData,
  output logic          overflow
);
  walkStrobe_t strobe;
  logic lastLevel;
  logic reqIsLocal;

  assign reqIsLocal = (reqLevels == '0);

  lw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsLocal(reqIsLocal),
    .lastLevel(lastLevel), .memRdAck(memRdAck), .resReady(resReady),
    .overflow(overflow), .strobe(strobe), .reqReady(reqReady),
    .memRdEn(memRdEn), .resValid(resValid), .busy(busy)
  );

  lw_dpath #(.AW(AW), .OW(OW), .LW(LW), .LINK_IDX(LINK_IDX)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLevels(reqLevels),
    .reqOffset(reqOffset), .frameBase(frameBase), .memRdData(memRdData),
    .linkAddr(memRdAddr), .sumAddr(resAddr), .lastLevel(lastLevel)
  );

  lw_guard #(.AW(AW)) i_guard (
    .clk(clk), .rstN(rstN), .spWr(spWr), .spData(spData),
    .hpWr(hpWr), .hpData(hpData), .overflow(overflow)
  );
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic [LW-1:0] reqLevels,
  input logic          memRdEn,
  input logic [AW-1:0] memRdAddr,
  input logic          memRdAck,
  input logic          resValid,
  input logic          resReady,
  input logic [AW-1:0] resAddr,
  input logic          busy,
  input logic          spWr,
  input logic          hpWr,
  input logic          overflow
);
  AST_LOCAL_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLevels == '0) |=> (resValid && !memRdEn)); // R2
  AST_FIRST_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLevels != '0) |=> memRdEn); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !resValid)); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memRdAck) |=> (memRdEn && $stable(memRdAddr))); // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resAddr))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(spWr || hpWr)); // R8
  AST_NO_OVERFLOW_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !reqReady); // R9
endmodule

bind lex_addr_walker lw_checker #(.AW(AW), .LW(LW)) i_lwChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqLevels(reqLevels), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .memRdAck(memRdAck), .resValid(resValid), .resReady(resReady),
  .resAddr(resAddr), .busy(busy), .spWr(spWr), .hpWr(hpWr),
  .overflow(overflow)
);

// File: tb/test_lex_addr_walker.sv
`timescale 1ns/1ps
module test_lex_addr_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqLevels = '0;
  logic [5:0] reqOffset = '0;
  logic [7:0] frameBase = '0;
  logic memRdEn;
  logic [7:0] memRdAddr;
  logic [7:0] memRdData = '0;
  logic memRdAck = 1'b0;
  logic resValid;
  logic resReady = 1'b0;
  logic [7:0] resAddr;
  logic busy;
  logic spWr = 1'b0;
  logic [7:0] spData = '0;
  logic hpWr = 1'b0;
  logic [7:0] hpData = '0;
  logic overflow;

  int vecCnt = 0;
  int errCnt = 0;
  logic [7:0] mem [256];
  logic [7:0] readLog [16];
  int readCnt = 0;
  int waitCnt = 0;
  logic [7:0] spModel = 8'hFF;
  logic [7:0] hpModel = 8'h00;
  bit ovfModel = 1'b0;

  always #4 clk = ~clk;

  lex_addr_walker i_lex_addr_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLevels(reqLevels), .reqOffset(reqOffset), .frameBase(frameBase),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memRdAck(memRdAck), .resValid(resValid), .resReady(resReady),
    .resAddr(resAddr), .busy(busy), .spWr(spWr), .spData(spData),
    .hpWr(hpWr), .hpData(hpData), .overflow(overflow)
  );

  // memory responder: random wait, one-cycle acknowledge
  always @(negedge clk) begin
    if (!rstN) begin
      memRdAck = 1'b0;
      waitCnt = 0;
    end else if (memRdAck) begin
      memRdAck = 1'b0;
      waitCnt = $urandom % 3;
    end else if (memRdEn) begin
      if (waitCnt == 0) begin
        memRdAck = 1'b1;
        memRdData = mem[memRdAddr];
        if (readCnt < 16) readLog[readCnt] = memRdAddr;
        readCnt++;
      end else begin
        waitCnt--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expWalk(input logic [3:0] lv, input logic [5:0] of,
                                         input logic [7:0] fb);
    logic [7:0] b = fb;
    for (int i = 0; i < int'(lv); i++) b = mem[b + 8'd3];
    return b + {2'b00, of};
  endfunction

  // called at a negedge
  task automatic doWalk(input logic [3:0] lv, input logic [5:0] of,
                        input logic [7:0] fb, input bit holdReq);
    logic [7:0] b;
    logic [7:0] expLink [16];
    logic [7:0] expRes;
    int cyc;
    b = fb;
    for (int i = 0; i < int'(lv); i++) begin
      expLink[i] = b + 8'd3;
      b = mem[expLink[i]];
    end
    expRes = expWalk(lv, of, fb);
    readCnt = 0;
    check(reqReady == 1'b1, "R6", "ready when idle", int'(reqReady), 1);
    reqValid = 1'b1; reqLevels = lv; reqOffset = of; frameBase = fb;
    @(negedge clk);
    if (holdReq) begin
      reqLevels = 4'($urandom); reqOffset = 6'($urandom); frameBase = 8'($urandom);
    end else begin
      reqValid = 1'b0;
    end
    check(busy == 1'b1, "R6", "busy after accept", int'(busy), 1);
    if (lv == 4'd0)
      check(resValid == 1'b1, "R2", "local result next cycle", int'(resValid), 1);
    cyc = 0;
    while (!resValid && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    check(resAddr == expRes, lv == 0 ? "R2" : "R4", "result address",
          int'(resAddr), int'(expRes));
    check(readCnt == int'(lv), "R3", "link read count", readCnt, int'(lv));
    for (int i = 0; i < int'(lv) && i < readCnt; i++)
      check(readLog[i] == expLink[i], "R3", "link read address",
            int'(readLog[i]), int'(expLink[i]));
    repeat ($urandom % 3) begin
      @(negedge clk);
      check(resValid && resAddr == expRes, "R7", "result held while stalled",
            int'(resAddr), int'(expRes));
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(!busy && !resValid, "R6", "idle after result taken",
          int'(busy), 0);
  endtask

  task automatic setPtr(input bit sw, input logic [7:0] sv,
                        input bit hw, input logic [7:0] hv);
    spWr = sw; spData = sv; hpWr = hw; hpData = hv;
    if (sw) spModel = sv;
    if (hw) hpModel = hv;
    if (sw || hw) ovfModel = ovfModel | (spModel <= hpModel);
    @(negedge clk);
    spWr = 1'b0; hpWr = 1'b0;
    check(overflow == ovfModel, "R8", "overflow after pointer update",
          int'(overflow), int'(ovfModel));
  endtask

  initial begin
    #(8 * 150000);
    errCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady at reset", int'(reqReady), 1);
    check(!busy && !resValid, "R1", "busy/resValid at reset", int'(busy), 0);
    check(!memRdEn, "R1", "memRdEn at reset", int'(memRdEn), 0);
    check(!overflow, "R1", "overflow at reset", int'(overflow), 0);

    // directed corners
    doWalk(4'd0, 6'd0, 8'd10, 1'b0);
    doWalk(4'd0, 6'd63, 8'd250, 1'b0);     // R2 wrap
    doWalk(4'd1, 6'd5, 8'd254, 1'b0);      // R3 link address wraps
    doWalk(4'd15, 6'd63, 8'd255, 1'b1);    // R6 request held during walk
    doWalk(4'd0, 6'd7, 8'd40, 1'b1);

    // random mix, pointers kept apart
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 10 < 7)
        doWalk(4'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
      else
        setPtr(1'($urandom), 8'd128 + 8'($urandom % 128),
               1'($urandom), 8'($urandom % 128));
    end

    // R8: simultaneous update where new values stay apart
    setPtr(1'b1, 8'd50, 1'b1, 8'd40);
    setPtr(1'b1, 8'd200, 1'b1, 8'd100);
    setPtr(1'b0, 8'd0, 1'b1, 8'd199);      // one apart, no overflow
    check(overflow == 1'b0, "R8", "adjacent pointers", int'(overflow), 0);
    setPtr(1'b0, 8'd0, 1'b1, 8'd200);      // meet
    check(overflow == 1'b1, "R8", "pointers met", int'(overflow), 1);
    // R9 requests refused while overflowed
    reqValid = 1'b1; reqLevels = 4'd0; reqOffset = 6'd1; frameBase = 8'd1;
    repeat (3) begin
      @(negedge clk);
      check(!reqReady && !busy && !resValid, "R9", "request refused on overflow",
            int'(busy), 0);
    end
    reqValid = 1'b0;
    setPtr(1'b1, 8'd250, 1'b1, 8'd0);      // R8 sticky
    check(overflow == 1'b1, "R8", "overflow sticky", int'(overflow), 1);
    repeat (2) @(negedge clk);
    check(!reqReady, "R9", "ready stays low", int'(reqReady), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule